// File: doc/BRIEF.md
# Top-of-Stack ALU with Carry and Overflow Flags

This unit holds the top-of-stack register and a scratch data register of a small stack processor, together with a carry flag and an overflow flag. Every clock cycle it executes one operation taken from a 5-bit field of the instruction word. The operand inputs come from registers that live outside the unit: the accumulator, the load register and the memory-address register.

The operation set covers several kinds of work. There are register moves and an exchange. There is wide addition with carry in and carry out. Subtraction uses borrow semantics, so the carry must be cleared before the low word is subtracted. There are rotates through carry and a one-bit multiply step. A sign-strip operation prepares signed multiply and divide, and a negate conditioned on overflow restores the sign afterwards. The remaining operations convert between the flags and the top-of-stack value.

Code 0 of the operation field means no operation. All state updates on the rising clock edge. The reset input is asynchronous and active low, and its release is synchronised inside the unit.

Top module: `tos_alu`

## Requirements
- R1: While reset is held low, and after it is released, BX, DX, CF and VF read 0. Code 0 leaves all four unchanged. VF is written only by codes 16, 21, 22, 23 and 24.
- R2: Code 1 loads LX into DX, code 2 loads AX into DX and code 3 loads BX into DX. Codes 6, 7, 8 and 9 load LX, AX, DX and MA into BX respectively. Code 10 exchanges BX and DX. None of these codes changes CF or VF.
- R3: Code 4 writes DX+AX into DX and code 5 writes AX+DX into BX. Code 11 writes the two's complement of BX into BX, code 14 writes BX+1 and code 15 writes BX-1. All results wrap modulo 2^16 and leave both flags unchanged.
- R4: Code 12 writes CF into BX, giving 1 or 0. Code 13 writes 1 into BX when BX is nonzero and leaves a zero BX as 0.
- R5: Code 21 writes BX+LX into BX and code 22 writes BX+AX into BX. CF receives the carry out of bit 15. VF is set to old BX bit 15 XOR new BX bit 15.
- R6: Code 23 writes BX+AX+CF into BX. CF and VF follow the same rules as in R5.
- R7: Code 24 writes BX-AX-CF into BX. CF becomes 1 exactly when BX < AX+CF taken as unsigned values, which is the borrow. VF follows the rule of R5.
- R8: Code 16 replaces BX and DX each by its absolute value; a value with bit 15 set is negated, and 0x8000 stays 0x8000. VF becomes the XOR of the original bit 15 of BX and DX. CF is unchanged.
- R9: Code 17 negates BX when VF is 1 and leaves BX unchanged when VF is 0.
- R10: Code 18 shifts DX right by one with 0 entering bit 15, and DX bit 0 goes to CF. In the same cycle it shifts BX left by one with 0 entering bit 0.
- R11: Code 19 rotates BX right through CF, so CF enters bit 15 and bit 0 goes to CF. Code 20 rotates BX left through CF, so CF enters bit 0 and bit 15 goes to CF.
- R12: Code 25 negates BX when bit 15 is set and copies the original bit 15 into CF.
- R13: Code 26 clears CF, code 27 copies VF into CF and code 28 inverts CF.
- R14: Code 29 sets CF to the OR of all BX bits. Code 30 sets CF to BX bit 15. Code 31 sets CF to BX bit 15 XOR VF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 5 | Operation field; 0 is no operation |
| ax_in | input | 16 | Accumulator operand |
| lx_in | input | 16 | Load-register operand |
| ma_in | input | 16 | Memory-address operand |
| bx_q | output | 16 | Top-of-stack register |
| dx_q | output | 16 | Scratch data register |
| cf_q | output | 1 | Carry flag |
| vf_q | output | 1 | Overflow flag |

## Verification
The bench checks that subtract-with-carry uses CF as a borrow in and returns a borrow. A design that inverts it in the usual two's-complement way gives a result one off and the opposite CF. The sign strip is driven with both operands negative, so VF must come out 0, and with 0x8000, which must stay unchanged. A wrong XOR or a saturating negate shows up in VF or BX. The conditional negate is applied with VF clear, so a design that negates unconditionally is caught. Rotates and the bit step are run in sequences where CF must travel around the register, which exposes swapped shift directions and a wrong carry source.

// File: rtl/tos_alu_pkg.sv
`timescale 1ns/1ps
package tos_alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP    = 5'd0,
    OP_DX_LX  = 5'd1,
    OP_DX_AX  = 5'd2,
    OP_DX_BX  = 5'd3,
    OP_DX_ADD = 5'd4,
    OP_BX_SUM = 5'd5,
    OP_BX_LX  = 5'd6,
    OP_BX_AX  = 5'd7,
    OP_BX_DX  = 5'd8,
    OP_BX_MA  = 5'd9,
    OP_SWAP   = 5'd10,
    OP_NEG    = 5'd11,
    OP_CF2BX  = 5'd12,
    OP_BOOL   = 5'd13,
    OP_INC    = 5'd14,
    OP_DEC    = 5'd15,
    OP_SGN    = 5'd16,
    OP_VNEG   = 5'd17,
    OP_BSTEP  = 5'd18,
    OP_ROR    = 5'd19,
    OP_ROL    = 5'd20,
    OP_ADDL   = 5'd21,
    OP_ADDA   = 5'd22,
    OP_ADC    = 5'd23,
    OP_SBC    = 5'd24,
    OP_ABS    = 5'd25,
    OP_CLC    = 5'd26,
    OP_V2C    = 5'd27,
    OP_CMC    = 5'd28,
    OP_TNZ    = 5'd29,
    OP_TNEG   = 5'd30,
    OP_TLT    = 5'd31
  } tos_op_e;

  typedef enum logic [1:0] {
    U_MOVE  = 2'd0,
    U_ARITH = 2'd1,
    U_SHIFT = 2'd2,
    U_FLAG  = 2'd3
  } tos_unit_e;

  function automatic tos_unit_e unit_of(input tos_op_e op);
    tos_unit_e u;
    case (op)
      OP_SGN, OP_VNEG, OP_ADDL, OP_ADDA,
      OP_ADC, OP_SBC, OP_ABS:            u = U_ARITH;
      OP_BSTEP, OP_ROR, OP_ROL:          u = U_SHIFT;
      OP_CLC, OP_V2C, OP_CMC,
      OP_TNZ, OP_TNEG, OP_TLT:           u = U_FLAG;
      default:                           u = U_MOVE;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/tos_alu_move.sv
`timescale 1ns/1ps
module tos_alu_move
  import tos_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  tos_op_e      op,
  input  logic [W-1:0] ax,
  input  logic [W-1:0] lx,
  input  logic [W-1:0] ma,
  input  logic [W-1:0] bx,
  input  logic [W-1:0] dx,
  input  logic         cf,
  output logic [W-1:0] bx_nx,
  output logic [W-1:0] dx_nx
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    bx_nx = bx;
    dx_nx = dx;
    case (op)
      OP_DX_LX:  dx_nx = lx;
      OP_DX_AX:  dx_nx = ax;
      OP_DX_BX:  dx_nx = bx;
      OP_DX_ADD: dx_nx = dx + ax;
      OP_BX_SUM: bx_nx = ax + dx;
      OP_BX_LX:  bx_nx = lx;
      OP_BX_AX:  bx_nx = ax;
      OP_BX_DX:  bx_nx = dx;
      OP_BX_MA:  bx_nx = ma;
      OP_SWAP: begin
        bx_nx = dx;
        dx_nx = bx;
      end
      OP_NEG:    bx_nx = '0 - bx;
      OP_CF2BX:  bx_nx = {{(W-1){1'b0}}, cf};
      OP_BOOL:   bx_nx = (bx != '0) ? ONE : '0;
      OP_INC:    bx_nx = bx + ONE;
      OP_DEC:    bx_nx = bx - ONE;
      default: ;
    endcase
  end
endmodule

// File: rtl/tos_alu_arith.sv
`timescale 1ns/1ps
module tos_alu_arith
  import tos_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  tos_op_e      op,
  input  logic [W-1:0] ax,
  input  logic [W-1:0] lx,
  input  logic [W-1:0] bx,
  input  logic [W-1:0] dx,
  input  logic         cf,
  input  logic         vf,
  output logic [W-1:0] bx_nx,
  output logic [W-1:0] dx_nx,
  output logic         cf_nx,
  output logic         vf_nx
);
  localparam int W1 = W + 1;

  logic [W-1:0] addend;
  logic         cin;
  logic [W:0]   wide;
  logic [W-1:0] bx_neg;
  logic [W-1:0] dx_neg;
  logic         bx_sign;
  logic         dx_sign;

  assign bx_sign = bx[W-1];
  assign dx_sign = dx[W-1];
  assign bx_neg  = '0 - bx;
  assign dx_neg  = '0 - dx;

  // one shared carry chain for every add and subtract
  always_comb begin
    addend = (op == OP_ADDL) ? lx : ax;
    cin    = (op == OP_ADC || op == OP_SBC) ? cf : 1'b0;
    if (op == OP_SBC)
      wide = {1'b0, bx} - {1'b0, addend} - W1'(cin);
    else
      wide = {1'b0, bx} + {1'b0, addend} + W1'(cin);
  end

  always_comb begin
    bx_nx = bx;
    dx_nx = dx;
    cf_nx = cf;
    vf_nx = vf;
    case (op)
      OP_ADDL, OP_ADDA, OP_ADC, OP_SBC: begin
        bx_nx = wide[W-1:0];
        cf_nx = wide[W];
        vf_nx = bx_sign ^ wide[W-1];
      end
      OP_SGN: begin
        bx_nx = bx_sign ? bx_neg : bx;
        dx_nx = dx_sign ? dx_neg : dx;
        vf_nx = bx_sign ^ dx_sign;
      end
      OP_VNEG: bx_nx = vf ? bx_neg : bx;
      OP_ABS: begin
        bx_nx = bx_sign ? bx_neg : bx;
        cf_nx = bx_sign;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tos_alu_shift.sv
`timescale 1ns/1ps
module tos_alu_shift
  import tos_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  tos_op_e      op,
  input  logic [W-1:0] bx,
  input  logic [W-1:0] dx,
  input  logic         cf,
  output logic [W-1:0] bx_nx,
  output logic [W-1:0] dx_nx,
  output logic         cf_nx
);
  always_comb begin
    bx_nx = bx;
    dx_nx = dx;
    cf_nx = cf;
    case (op)
      OP_BSTEP: begin
        dx_nx = {1'b0, dx[W-1:1]};
        cf_nx = dx[0];
        bx_nx = {bx[W-2:0], 1'b0};
      end
      OP_ROR: begin
        bx_nx = {cf, bx[W-1:1]};
        cf_nx = bx[0];
      end
      OP_ROL: begin
        bx_nx = {bx[W-2:0], cf};
        cf_nx = bx[W-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tos_alu_flag.sv
`timescale 1ns/1ps
module tos_alu_flag
  import tos_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  tos_op_e      op,
  input  logic [W-1:0] bx,
  input  logic         cf,
  input  logic         vf,
  output logic         cf_nx
);
  always_comb begin
    cf_nx = cf;
    case (op)
      OP_CLC:  cf_nx = 1'b0;
      OP_V2C:  cf_nx = vf;
      OP_CMC:  cf_nx = ~cf;
      OP_TNZ:  cf_nx = |bx;
      OP_TNEG: cf_nx = bx[W-1];
      OP_TLT:  cf_nx = bx[W-1] ^ vf;
      default: ;
    endcase
  end
endmodule

// File: rtl/tos_alu.sv
`timescale 1ns/1ps
module tos_alu
  import tos_alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int OPW     = 5,
  parameter int SYNC_FF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPW-1:0]   op_code,
  input  logic [WIDTH-1:0] ax_in,
  input  logic [WIDTH-1:0] lx_in,
  input  logic [WIDTH-1:0] ma_in,
  output logic [WIDTH-1:0] bx_q,
  output logic [WIDTH-1:0] dx_q,
  output logic             cf_q,
  output logic             vf_q
);
  tos_op_e op;
  assign op = tos_op_e'(op_code);

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_FF-1:0] rst_sync;
  logic               rst_loc_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_FF-2:0], 1'b1};
  end
  assign rst_loc_n = rst_sync[SYNC_FF-1];

  logic [WIDTH-1:0] bx_r, dx_r, bx_nx, dx_nx;
  logic             cf_r, vf_r, cf_nx, vf_nx;
  logic             state_en;

  logic [WIDTH-1:0] mv_bx, mv_dx, ar_bx, ar_dx, sh_bx, sh_dx;
  logic             ar_cf, ar_vf, sh_cf, fl_cf;

  tos_alu_move #(.W(WIDTH)) u_move (
    .op(op), .ax(ax_in), .lx(lx_in), .ma(ma_in),
    .bx(bx_r), .dx(dx_r), .cf(cf_r),
    .bx_nx(mv_bx), .dx_nx(mv_dx)
  );

  tos_alu_arith #(.W(WIDTH)) u_arith (
    .op(op), .ax(ax_in), .lx(lx_in),
    .bx(bx_r), .dx(dx_r), .cf(cf_r), .vf(vf_r),
    .bx_nx(ar_bx), .dx_nx(ar_dx), .cf_nx(ar_cf), .vf_nx(ar_vf)
  );

  tos_alu_shift #(.W(WIDTH)) u_shift (
    .op(op), .bx(bx_r), .dx(dx_r), .cf(cf_r),
    .bx_nx(sh_bx), .dx_nx(sh_dx), .cf_nx(sh_cf)
  );

  tos_alu_flag #(.W(WIDTH)) u_flag (
    .op(op), .bx(bx_r), .cf(cf_r), .vf(vf_r),
    .cf_nx(fl_cf)
  );

  always_comb begin
    bx_nx = bx_r;
    dx_nx = dx_r;
    cf_nx = cf_r;
    vf_nx = vf_r;
    case (unit_of(op))
      U_MOVE: begin
        bx_nx = mv_bx;
        dx_nx = mv_dx;
      end
      U_ARITH: begin
        bx_nx = ar_bx;
        dx_nx = ar_dx;
        cf_nx = ar_cf;
        vf_nx = ar_vf;
      end
      U_SHIFT: begin
        bx_nx = sh_bx;
        dx_nx = sh_dx;
        cf_nx = sh_cf;
      end
      U_FLAG: cf_nx = fl_cf;
      default: ;
    endcase
  end

  assign state_en = (op != OP_NOP);

  always_ff @(posedge clk or negedge rst_loc_n) begin
    if (!rst_loc_n) begin
      bx_r <= '0;
      dx_r <= '0;
      cf_r <= 1'b0;
      vf_r <= 1'b0;
    end else if (state_en) begin
      bx_r <= bx_nx;
      dx_r <= dx_nx;
      cf_r <= cf_nx;
      vf_r <= vf_nx;
    end
  end

  assign bx_q = bx_r;
  assign dx_q = dx_r;
  assign cf_q = cf_r;
  assign vf_q = vf_r;
endmodule

// File: rtl/tos_alu_chk.sv
`timescale 1ns/1ps
module tos_alu_chk
  import tos_alu_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [4:0]   op,
  input logic [W-1:0] ax,
  input logic [W-1:0] bx,
  input logic [W-1:0] dx,
  input logic         cf,
  input logic         vf
);
  localparam int W1 = W + 1;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    op == OP_NOP |=> $stable(bx) && $stable(dx) && $stable(cf) && $stable(vf));

  // R2
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    op == OP_SWAP |=> bx == $past(dx) && dx == $past(bx) && $stable(cf));

  // R6
  adc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    op == OP_ADC |=> {cf, bx} == ({1'b0, $past(bx)} + {1'b0, $past(ax)} + W1'($past(cf))));

  // R7
  sbc_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    op == OP_SBC |=> cf == ({1'b0, $past(bx)} < ({1'b0, $past(ax)} + W1'($past(cf)))));

  // R8
  sgn_vf_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    op == OP_SGN |=> vf == ($past(bx[W-1]) ^ $past(dx[W-1])) && !bx[W-1] || bx == $past(bx));

  // R10
  bstep_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    op == OP_BSTEP |=> cf == $past(dx[0]) && !dx[W-1] && !bx[0]);

  // R13
  cmc_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    op == OP_CMC |=> cf != $past(cf) && $stable(bx));

  // R14
  tneg_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    op == OP_TNEG |=> cf == bx[W-1] && $stable(bx));
endmodule

bind tos_alu tos_alu_chk #(.W(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op_code), .ax(ax_in),
  .bx(bx_q), .dx(dx_q), .cf(cf_q), .vf(vf_q)
);

// File: tb/tos_alu_bench.sv
`timescale 1ns/1ps
module tos_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_code = '0;
  logic [15:0] ax_in = '0, lx_in = '0, ma_in = '0;
  logic [15:0] bx_q, dx_q;
  logic        cf_q, vf_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tos_alu u_tos_alu (
    .clk(clk), .rst_n(rst_n), .op_code(op_code),
    .ax_in(ax_in), .lx_in(lx_in), .ma_in(ma_in),
    .bx_q(bx_q), .dx_q(dx_q), .cf_q(cf_q), .vf_q(vf_q)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] ax, lx, ma, bx, dx;
    logic        cf, vf;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    '{5'd6,  16'h0000, 16'h1234, 16'h0000, 16'h1234, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2
    '{5'd1,  16'h0000, 16'h00FF, 16'h0000, 16'h1234, 16'h00FF, 1'b0, 1'b0, 4'd2},  // R2
    '{5'd10, 16'h0000, 16'h0000, 16'h0000, 16'h00FF, 16'h1234, 1'b0, 1'b0, 4'd2},  // R2 swap
    '{5'd7,  16'h8000, 16'h0000, 16'h0000, 16'h8000, 16'h1234, 1'b0, 1'b0, 4'd2},  // R2
    '{5'd9,  16'h0000, 16'h0000, 16'h0042, 16'h0042, 16'h1234, 1'b0, 1'b0, 4'd2},  // R2
    '{5'd8,  16'h0000, 16'h0000, 16'h0000, 16'h1234, 16'h1234, 1'b0, 1'b0, 4'd2},  // R2
    '{5'd2,  16'h0003, 16'h0000, 16'h0000, 16'h1234, 16'h0003, 1'b0, 1'b0, 4'd2},  // R2
    '{5'd3,  16'h0000, 16'h0000, 16'h0000, 16'h1234, 16'h1234, 1'b0, 1'b0, 4'd2},  // R2
    '{5'd4,  16'h0001, 16'h0000, 16'h0000, 16'h1234, 16'h1235, 1'b0, 1'b0, 4'd3},  // R3
    '{5'd5,  16'h0002, 16'h0000, 16'h0000, 16'h1237, 16'h1235, 1'b0, 1'b0, 4'd3},  // R3
    '{5'd11, 16'h0000, 16'h0000, 16'h0000, 16'hEDC9, 16'h1235, 1'b0, 1'b0, 4'd3},  // R3 negate
    '{5'd14, 16'h0000, 16'h0000, 16'h0000, 16'hEDCA, 16'h1235, 1'b0, 1'b0, 4'd3},  // R3
    '{5'd15, 16'h0000, 16'h0000, 16'h0000, 16'hEDC9, 16'h1235, 1'b0, 1'b0, 4'd3},  // R3
    '{5'd22, 16'h2000, 16'h0000, 16'h0000, 16'h0DC9, 16'h1235, 1'b1, 1'b1, 4'd5},  // R5 carry out
    '{5'd23, 16'h0001, 16'h0000, 16'h0000, 16'h0DCB, 16'h1235, 1'b0, 1'b0, 4'd6},  // R6
    '{5'd24, 16'h0DCC, 16'h0000, 16'h0000, 16'hFFFF, 16'h1235, 1'b1, 1'b1, 4'd7},  // R7 borrow
    '{5'd12, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h1235, 1'b1, 1'b1, 4'd4},  // R4
    '{5'd26, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h1235, 1'b0, 1'b1, 4'd13}, // R13
    '{5'd27, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h1235, 1'b1, 1'b1, 4'd13}, // R13
    '{5'd28, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h1235, 1'b0, 1'b1, 4'd13}, // R13
    '{5'd29, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h1235, 1'b1, 1'b1, 4'd14}, // R14
    '{5'd30, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h1235, 1'b0, 1'b1, 4'd14}, // R14
    '{5'd31, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h1235, 1'b1, 1'b1, 4'd14}, // R14
    '{5'd24, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h1235, 1'b0, 1'b0, 4'd7},  // R7 borrow in
    '{5'd13, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h1235, 1'b0, 1'b0, 4'd4},  // R4 zero stays
    '{5'd21, 16'h0000, 16'h7FFF, 16'h0000, 16'h7FFF, 16'h1235, 1'b0, 1'b0, 4'd5},  // R5
    '{5'd21, 16'h0000, 16'h0001, 16'h0000, 16'h8000, 16'h1235, 1'b0, 1'b1, 4'd5},  // R5 sign change
    '{5'd25, 16'h0000, 16'h0000, 16'h0000, 16'h8000, 16'h1235, 1'b1, 1'b1, 4'd12}, // R12
    '{5'd13, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h1235, 1'b1, 1'b1, 4'd4},  // R4
    '{5'd17, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h1235, 1'b1, 1'b1, 4'd9},  // R9
    '{5'd6,  16'h0000, 16'h0001, 16'h0000, 16'h0001, 16'h1235, 1'b1, 1'b1, 4'd2},  // R2
    '{5'd26, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h1235, 1'b0, 1'b1, 4'd13}, // R13
    '{5'd19, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h1235, 1'b1, 1'b1, 4'd11}, // R11
    '{5'd19, 16'h0000, 16'h0000, 16'h0000, 16'h8000, 16'h1235, 1'b0, 1'b1, 4'd11}, // R11
    '{5'd20, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h1235, 1'b1, 1'b1, 4'd11}, // R11
    '{5'd20, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h1235, 1'b0, 1'b1, 4'd11}, // R11
    '{5'd7,  16'hFFFD, 16'h0000, 16'h0000, 16'hFFFD, 16'h1235, 1'b0, 1'b1, 4'd2},  // R2
    '{5'd16, 16'h0000, 16'h0000, 16'h0000, 16'h0003, 16'h1235, 1'b0, 1'b1, 4'd8},  // R8
    '{5'd17, 16'h0000, 16'h0000, 16'h0000, 16'hFFFD, 16'h1235, 1'b0, 1'b1, 4'd9},  // R9
    '{5'd18, 16'h0000, 16'h0000, 16'h0000, 16'hFFFA, 16'h091A, 1'b1, 1'b1, 4'd10}, // R10
    '{5'd0,  16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFA, 16'h091A, 1'b1, 1'b1, 4'd1}   // R1 hold
  };

  task automatic compare(input logic [15:0] ebx, edx, input logic ecf, evf, input int req);
    checks++;
    if (bx_q !== ebx || dx_q !== edx || cf_q !== ecf || vf_q !== evf) begin
      failures++;
      $display("FAIL R%0d: bx=%h dx=%h cf=%b vf=%b expected bx=%h dx=%h cf=%b vf=%b",
               req, bx_q, dx_q, cf_q, vf_q, ebx, edx, ecf, evf);
    end
  endtask

  task automatic step(input logic [4:0] op, input logic [15:0] ax, lx, ma,
                      input logic [15:0] ebx, edx, input logic ecf, evf, input int req);
    op_code = op; ax_in = ax; lx_in = lx; ma_in = ma;
    @(posedge clk);
    @(negedge clk);
    compare(ebx, edx, ecf, evf, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    op_code = '0;
    rst_n = 1'b0;
    #1;
    compare(16'h0000, 16'h0000, 1'b0, 1'b0, 1);  // R1 asynchronous clear
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(16'h0000, 16'h0000, 1'b0, 1'b0, 1);  // R1 after release
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(16'h0000, 16'h0000, 1'b0, 1'b0, 1);  // R1 held in reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(16'h0000, 16'h0000, 1'b0, 1'b0, 1);  // R1

    for (int i = 0; i < NV; i++)
      step(VEC[i].op, VEC[i].ax, VEC[i].lx, VEC[i].ma,
           VEC[i].bx, VEC[i].dx, VEC[i].cf, VEC[i].vf, int'(VEC[i].req));

    do_reset();
    // R8: both operands negative, signs cancel in VF
    step(5'd7,  16'hFFFF, 16'h0, 16'h0, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 8);
    step(5'd2,  16'h8000, 16'h0, 16'h0, 16'hFFFF, 16'h8000, 1'b0, 1'b0, 8);
    step(5'd16, 16'h0000, 16'h0, 16'h0, 16'h0001, 16'h8000, 1'b0, 1'b0, 8);
    // R9: VF clear, BX must stay
    step(5'd17, 16'h0000, 16'h0, 16'h0, 16'h0001, 16'h8000, 1'b0, 1'b0, 9);
    // R7: equal operands, no borrow
    step(5'd24, 16'h0001, 16'h0, 16'h0, 16'h0000, 16'h8000, 1'b0, 1'b0, 7);
    // R13 set CF, then R7 borrow in from zero
    step(5'd28, 16'h0000, 16'h0, 16'h0, 16'h0000, 16'h8000, 1'b1, 1'b0, 13);
    step(5'd24, 16'h0000, 16'h0, 16'h0, 16'hFFFF, 16'h8000, 1'b1, 1'b1, 7);
    // R6: carry in wraps to zero
    step(5'd23, 16'h0000, 16'h0, 16'h0, 16'h0000, 16'h8000, 1'b1, 1'b1, 6);
    // R14: zero BX test, and sign xor VF
    step(5'd29, 16'h0000, 16'h0, 16'h0, 16'h0000, 16'h8000, 1'b0, 1'b1, 14);
    step(5'd31, 16'h0000, 16'h0, 16'h0, 16'h0000, 16'h8000, 1'b1, 1'b1, 14);
    // R10: bit step with DX bit 0 clear
    step(5'd18, 16'h0000, 16'h0, 16'h0, 16'h0000, 16'h4000, 1'b0, 1'b1, 10);
    // R12: positive BX keeps value, CF cleared
    step(5'd6,  16'h0000, 16'h0005, 16'h0, 16'h0005, 16'h4000, 1'b0, 1'b1, 2);
    step(5'd25, 16'h0000, 16'h0, 16'h0, 16'h0005, 16'h4000, 1'b0, 1'b1, 12);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1: watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule